// File: doc/BRIEF.md
# Add/Subtract/Step ALU with Left Shift

This block is a purely combinational arithmetic unit for small two's complement words (4 bits by default). It takes two operands and a 3-bit operation select and returns a result word and a carry out. Addition, subtraction, increment and decrement all pass through a single ripple-carry adder. Two independent control bits shape the second adder operand. One bit replaces B with the constant one. The other bit inverts the operand and feeds a carry into the first stage.

A third select bit picks a one-place arithmetic left shift of A, which is built outside the adder. This shift path takes priority over everything else. Each adder stage is a full adder made of two half adders whose carries are ORed. The operands are read as two's complement, so the top bit has weight −8, but the word result is the same whether they are read as signed or unsigned.

Top module: `addsub_shift_alu`

## Requirements
- R1: With `op_sel` = 3'b000, `res_out` = (A + B) mod 16 and `carry_out` is the fifth bit of the unsigned sum.
- R2: With `op_sel` = 3'b010 (bit 1 is the negate control), `res_out` = (A − B) mod 16 and `carry_out` = 1 exactly when A ≥ B as unsigned values. This comes from adding A, the inverted B and a carry-in of 1.
- R3: With `op_sel` = 3'b001 (bit 0 is the force-one control), `res_out` = (A + 1) mod 16 and `carry_out` = 1 only when A = 4'b1111.
- R4: With `op_sel` = 3'b011, `res_out` = (A − 1) mod 16 and `carry_out` = 1 exactly when A ≠ 0.
- R5: Whenever `op_sel[2]` = 1, `res_out` = {A[2:0], 1'b0} and `carry_out` = A[3], whatever the values of `op_sel[1:0]`.
- R6: B has no effect on either output for increment, decrement and every shift code.
- R7: A carry generated in any stage ripples through all later stages. For example, 4'b1111 + 4'b0001 gives a result of 0 and a carry out of 1, and each full adder stage produces {carry, sum} equal to the arithmetic sum of its three input bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 4 | Operand A (two's complement) |
| b_in | input | 4 | Operand B (two's complement) |
| op_sel | input | 3 | Operation: bit 2 selects the shift, bit 1 negates, bit 0 forces the second operand to one |
| res_out | output | 4 | Result word |
| carry_out | output | 1 | Carry from the last adder stage, or A[3] for the shift |

## Verification
Immediate assertions are evaluated on every input change. They tie each operation code at the ports to its arithmetic meaning (R1 to R5), and they check each full-adder stage against the sum of its three input bits (R7). The independence from B (R6) cannot be seen from a single input value. Only the bench shows it: it sweeps every B for the increment, decrement and shift codes and compares the results against a model that never looks at B. The full ripple across all stages is also covered by the bench's exhaustive sweep over every operand pair.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned ALU_W  = 4;
    localparam int unsigned OP_W   = 3;

    // op_sel bit positions
    localparam int unsigned BIT_ONE = 0;
    localparam int unsigned BIT_NEG = 1;
    localparam int unsigned BIT_SHL = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'b000,
        OP_INC = 3'b001,
        OP_SUB = 3'b010,
        OP_DEC = 3'b011,
        OP_SHL = 3'b100
    } alu_op_e;

    typedef struct packed {
        logic shift;
        logic negate;
        logic use_one;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] op);
        alu_ctrl_t c;
        c.shift   = op[BIT_SHL];
        c.negate  = op[BIT_NEG];
        c.use_one = op[BIT_ONE];
        return c;
    endfunction

endpackage

// File: rtl/alu_half_add.sv
module alu_half_add (
    input  logic x_in,
    input  logic y_in,
    output logic s_out,
    output logic c_out
);
    always_comb begin
        s_out = x_in ^ y_in;
        c_out = x_in & y_in;
    end
endmodule

// File: rtl/alu_full_add.sv
module alu_full_add (
    input  logic x_in,
    input  logic y_in,
    input  logic c_in,
    output logic s_out,
    output logic c_out
);
    logic s_first, c_first, c_second;

    alu_half_add i_ha_lo (
        .x_in (x_in),
        .y_in (y_in),
        .s_out(s_first),
        .c_out(c_first)
    );

    alu_half_add i_ha_hi (
        .x_in (s_first),
        .y_in (c_in),
        .s_out(s_out),
        .c_out(c_second)
    );

    assign c_out = c_first | c_second;

    // R7: stage output equals arithmetic sum of its three bits
    always_comb begin
        p_stage_sum_r7: assert ({c_out, s_out} ==
            ({1'b0, x_in} + {1'b0, y_in} + {1'b0, c_in}))
            else $error("stage sum mismatch");
    end
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic         c_in,
    output logic [W-1:0] s_out,
    output logic         c_out
);
    logic [W:0] chain;

    assign chain[0] = c_in;

    for (genvar k = 0; k < W; k++) begin : g_stage
        alu_full_add i_fa (
            .x_in (x_in[k]),
            .y_in (y_in[k]),
            .c_in (chain[k]),
            .s_out(s_out[k]),
            .c_out(chain[k+1])
        );
    end

    assign c_out = chain[W];
endmodule

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] b_in,
    input  logic         use_one,
    input  logic         negate,
    output logic [W-1:0] b_mod,
    output logic         c_inject
);
    localparam logic [W-1:0] CONST_ONE = W'(1);

    logic [W-1:0] b_sel;

    always_comb begin
        b_sel    = use_one ? CONST_ONE : b_in;
        b_mod    = b_sel ^ {W{negate}};
        c_inject = negate;
    end
endmodule

// File: rtl/addsub_shift_alu.sv
module addsub_shift_alu
    import alu_pkg::*;
#(
    parameter int unsigned W = ALU_W
) (
    input  logic [W-1:0]    a_in,
    input  logic [W-1:0]    b_in,
    input  logic [OP_W-1:0] op_sel,
    output logic [W-1:0]    res_out,
    output logic            carry_out
);
    localparam logic [W-1:0] ONE_W = W'(1);

    alu_ctrl_t    ctrl;
    logic [W-1:0] b_mod;
    logic         c_inject;
    logic [W-1:0] sum_w;
    logic         sum_c;
    logic [W-1:0] shl_w;

    assign ctrl = decode_op(op_sel);

    alu_operand_prep #(.W(W)) i_prep (
        .b_in    (b_in),
        .use_one (ctrl.use_one),
        .negate  (ctrl.negate),
        .b_mod   (b_mod),
        .c_inject(c_inject)
    );

    alu_ripple_add #(.W(W)) i_adder (
        .x_in (a_in),
        .y_in (b_mod),
        .c_in (c_inject),
        .s_out(sum_w),
        .c_out(sum_c)
    );

    assign shl_w = {a_in[W-2:0], 1'b0};

    always_comb begin
        if (ctrl.shift) begin
            res_out   = shl_w;
            carry_out = a_in[W-1];
        end else begin
            res_out   = sum_w;
            carry_out = sum_c;
        end
    end

    // Port-level checks of each operation against its arithmetic meaning
    always_comb begin
        if (op_sel == OP_ADD) begin
            p_add_r1: assert ({carry_out, res_out} == ({1'b0, a_in} + {1'b0, b_in}))
                else $error("add mismatch");
        end
        if (op_sel == OP_SUB) begin
            p_sub_r2: assert (res_out == W'(a_in - b_in) && carry_out == (a_in >= b_in))
                else $error("sub mismatch");
        end
        if (op_sel == OP_INC) begin
            p_inc_r3: assert (res_out == W'(a_in + ONE_W) && carry_out == (a_in == {W{1'b1}}))
                else $error("inc mismatch");
        end
        if (op_sel == OP_DEC) begin
            p_dec_r4: assert (res_out == W'(a_in - ONE_W) && carry_out == (a_in != '0))
                else $error("dec mismatch");
        end
        if (op_sel[BIT_SHL]) begin
            p_shift_r5: assert (res_out[0] == 1'b0 && res_out[W-1:1] == a_in[W-2:0]
                                && carry_out == a_in[W-1])
                else $error("shift mismatch");
        end
    end
endmodule

// File: tb/test_addsub_shift_alu.sv
module test_addsub_shift_alu;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a, b;
    logic [2:0] op;
    logic [3:0] res;
    logic       cout;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    addsub_shift_alu i_addsub_shift_alu (
        .a_in     (a),
        .b_in     (b),
        .op_sel   (op),
        .res_out  (res),
        .carry_out(cout)
    );

    // entry: {op[2:0], a[3:0], b[3:0], cout, res[3:0]}
    localparam int NV = 16;
    localparam logic [15:0] VEC [NV] = '{
        {3'b000, 4'd3,  4'd4,  1'b0, 4'd7 },  // R1
        {3'b000, 4'd9,  4'd8,  1'b1, 4'd1 },  // R1
        {3'b000, 4'd7,  4'd1,  1'b0, 4'd8 },  // R1 signed wrap
        {3'b000, 4'd15, 4'd1,  1'b1, 4'd0 },  // R7 full ripple
        {3'b010, 4'd7,  4'd3,  1'b1, 4'd4 },  // R2
        {3'b010, 4'd3,  4'd7,  1'b0, 4'd12},  // R2
        {3'b010, 4'd0,  4'd0,  1'b1, 4'd0 },  // R2
        {3'b001, 4'd5,  4'd9,  1'b0, 4'd6 },  // R3, R6
        {3'b001, 4'd15, 4'd0,  1'b1, 4'd0 },  // R3
        {3'b011, 4'd0,  4'd5,  1'b0, 4'd15},  // R4, R6
        {3'b011, 4'd8,  4'd0,  1'b1, 4'd7 },  // R4
        {3'b100, 4'd11, 4'd0,  1'b1, 4'd6 },  // R5
        {3'b100, 4'd5,  4'd15, 1'b0, 4'd10},  // R5, R6
        {3'b111, 4'd9,  4'd3,  1'b1, 4'd2 },  // R5 override
        {3'b110, 4'd0,  4'd7,  1'b0, 4'd0 },  // R5 override
        {3'b101, 4'd15, 4'd9,  1'b1, 4'd14}   // R5 override
    };

    task automatic drive_and_check(input logic [2:0] o, input logic [3:0] av,
                                   input logic [3:0] bv, input logic ec,
                                   input logic [3:0] er, input string tag);
        @(posedge clk);
        op = o; a = av; b = bv;
        @(negedge clk);
        n_checks++;
        if (res !== er || cout !== ec) begin
            n_errors++;
            $display("FAIL %s op=%b a=%0d b=%0d: got res=%0d c=%b, expected res=%0d c=%b",
                     tag, o, av, bv, res, cout, er, ec);
        end
    endtask

    function automatic logic [4:0] model(input logic [2:0] o, input logic [3:0] av,
                                         input logic [3:0] bv);
        logic [4:0] t;
        logic [3:0] second;
        if (o[2]) return {av[3], av[2:0], 1'b0};
        second = o[0] ? 4'd1 : bv;
        if (o[1]) t = {1'b0, av} + {1'b0, ~second} + 5'd1;
        else      t = {1'b0, av} + {1'b0, second};
        return t;
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        if (o[2]) return "R5/R6";
        case (o[1:0])
            2'b00:   return "R1/R7";
            2'b10:   return "R2";
            2'b01:   return "R3/R6";
            default: return "R4/R6";
        endcase
    endfunction

    initial begin
        a = '0; b = '0; op = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle state: all-zero inputs give zero result and no carry (R1)
        @(negedge clk);
        n_checks++;
        if (res !== 4'd0 || cout !== 1'b0) begin
            n_errors++;
            $display("FAIL R1 idle: got res=%0d c=%b, expected res=0 c=0", res, cout);
        end

        for (int i = 0; i < NV; i++) begin
            drive_and_check(VEC[i][15:13], VEC[i][12:9], VEC[i][8:5],
                            VEC[i][4], VEC[i][3:0], "table");
        end

        // exhaustive sweep: every op, every A, every B
        for (int o = 0; o < 8; o++) begin
            for (int ai = 0; ai < 16; ai++) begin
                for (int bi = 0; bi < 16; bi++) begin
                    logic [4:0] e;
                    e = model(3'(o), 4'(ai), 4'(bi));
                    drive_and_check(3'(o), 4'(ai), 4'(bi), e[4], e[3:0], tag_of(3'(o)));
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule